// File: doc/BRIEF.md
# Memory Pattern Write-Verify Engine

This engine checks a region of word-addressed memory through a plain master port. A single-cycle `start` pulse captures a base address. The engine then writes a fixed 32-bit test pattern to consecutive addresses starting at that base. Once every word has been written, it reads the region back, fetching each word several times in a row before it moves to the next address.

The first read that returns something other than the expected word ends the test at once. The engine raises `fail` and records the index of the word that failed. If every read matches, the test passes.

The pattern is built by combinational logic. It has four groups of sixteen words. Each group alternates two complementary-looking values in a fixed order of pairs, which exercises both data-bit polarities and adjacent-bit toggles. Every transfer uses a request/ready handshake, and every read waits for a valid strobe, so the engine works against memory of any latency.

Top module: `mem_pattern_verify`

## Requirements
- R1: Word i of the pattern (i taken modulo 64) belongs to group i/16 (bits 5:4 of the index). Each group has a value pair (A, B): group 0 is 0x00000000/0xFFFFFFFF, group 1 is 0xAAAAAAAA/0x55555555, group 2 is 0xA5A5A5A5/0x5A5A5A5A and group 3 is 0xAA55AA55/0x55AA55AA.
- R2: Inside a group, a word takes value B when bit 1 XOR bit 3 of its index is 1, and value A otherwise. This gives the order A A B B A A B B B B A A B B A A.
- R3: After `start`, the engine writes all WORDS words (default 64), one per accepted request, to addresses base+0 through base+WORDS-1 in ascending order. It issues no read until the last write has been accepted.
- R4: In the read phase, each address from base upwards is read REPEATS times in a row (default 10) before the next address is read.
- R5: On the first read whose returned data differs from the expected word, the engine sets `fail` to 1 and sets `failIdx` to that word's index. It issues no further request.
- R6: When every read of every word matches, the test ends with `fail` equal to 0 and `failIdx` equal to 0, after exactly WORDS*REPEATS reads.
- R7: A request is accepted only in a cycle where `memReady` is 1. While `memReq` is held without `memReady`, `memAddr` and `memWdata` stay stable. A read is compared only when `memRvalid` arrives.
- R8: A `start` pulse that arrives while the engine is busy, including the cycle in which `done` is high, is ignored. It does not change the base address, the transfer sequence or the result, and no new test begins.
- R9: `done` is high for exactly one cycle at the end of a test. `fail` and `failIdx` keep their values until the next accepted `start`.
- R10: After reset, `memReq`, `done`, `fail` and `failIdx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test (accepted when idle) |
| baseAddr | input | AW | First word address of the tested region |
| memReq | output | 1 | Transfer request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | AW | Word address |
| memWdata | output | 32 | Write data (expected data in the read phase) |
| memReady | input | 1 | Memory accepts the current request |
| memRdata | input | 32 | Read data |
| memRvalid | input | 1 | Read data valid |
| done | output | 1 | One-cycle end-of-test pulse |
| fail | output | 1 | Test failed |
| failIdx | output | IW | Index of the first failing word |

## Verification
Two functions can land in the same cycle, and the bench provokes both overlaps deliberately.

The first overlap is a new `start` pulse in the same cycle as the end-of-test `done` pulse. The bench drives `start` exactly in that cycle. It then judges that `memReq` stays low for the following cycles and that the result flags hold.

The second overlap is a mismatch on the very last read of the last word, which competes with normal completion. The bench injects a fault into that read and expects `fail` with index WORDS-1 and a read count of WORDS*REPEATS. Random stall and latency patterns, together with random fault positions, cover the remaining orderings.

// File: rtl/mpv_pkg.sv
package mpv_pkg;

  localparam int PAT_W = 32;

  typedef struct packed {
    logic load;
    logic idxClr;
    logic idxInc;
    logic repClr;
    logic repInc;
    logic setFail;
  } mpvStrobe_t;

  // Pattern word for index i: group in bits 5:4, B selected by bit1 ^ bit3.
  function automatic logic [PAT_W-1:0] patternWord(input logic [5:0] i);
    logic [PAT_W-1:0] valA;
    logic [PAT_W-1:0] valB;
    case (i[5:4])
      2'd0:    begin valA = 32'h0000_0000; valB = 32'hFFFF_FFFF; end
      2'd1:    begin valA = 32'hAAAA_AAAA; valB = 32'h5555_5555; end
      2'd2:    begin valA = 32'hA5A5_A5A5; valB = 32'h5A5A_5A5A; end
      default: begin valA = 32'hAA55_AA55; valB = 32'h55AA_55AA; end
    endcase
    return (i[3] ^ i[1]) ? valB : valA;
  endfunction

endpackage

// File: rtl/mpv_ctrl.sv
module mpv_ctrl
  import mpv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       memReady,
  input  logic       memRvalid,
  input  logic       idxLast,
  input  logic       repLast,
  input  logic       mismatch,
  output mpvStrobe_t strb,
  output logic       memReq,
  output logic       memWe,
  output logic       done
);

  typedef enum logic [2:0] {
    S_IDLE,
    S_WRITE,
    S_RDREQ,
    S_RDWAIT,
    S_FIN
  } state_t;

  state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    done      = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          nextState = S_WRITE;
        end
      end
      S_WRITE: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memReady) begin
          if (idxLast) begin
            strb.idxClr = 1'b1;
            nextState   = S_RDREQ;
          end else begin
            strb.idxInc = 1'b1;
          end
        end
      end
      S_RDREQ: begin
        memReq = 1'b1;
        if (memReady) nextState = S_RDWAIT;
      end
      S_RDWAIT: begin
        if (memRvalid) begin
          if (mismatch) begin
            strb.setFail = 1'b1;
            nextState    = S_FIN;
          end else if (repLast) begin
            strb.repClr = 1'b1;
            if (idxLast) begin
              nextState = S_FIN;
            end else begin
              strb.idxInc = 1'b1;
              nextState   = S_RDREQ;
            end
          end else begin
            strb.repInc = 1'b1;
            nextState   = S_RDREQ;
          end
        end
      end
      S_FIN: begin
        done      = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_STOP_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RDWAIT && memRvalid && mismatch) |=> (done && !memReq)); // R5
  AST_READS_AFTER_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && $past(memReq && memWe)) |-> $past(idxLast && memReady)); // R3
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RDWAIT && !memRvalid && start) |=> (state == S_RDWAIT)); // R8
  AST_FIN_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FIN) |=> (state == S_IDLE && !memReq)); // R8

endmodule

// File: rtl/mpv_datapath.sv
module mpv_datapath
  import mpv_pkg::*;
#(
  parameter int AW      = 16,
  parameter int WORDS   = 64,
  parameter int REPEATS = 10,
  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int RW = (REPEATS > 1) ? $clog2(REPEATS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  mpvStrobe_t       strb,
  input  logic [AW-1:0]    baseAddr,
  input  logic [PAT_W-1:0] memRdata,
  input  logic             memReq,
  input  logic             memReady,
  output logic [AW-1:0]    memAddr,
  output logic [PAT_W-1:0] memWdata,
  output logic             idxLast,
  output logic             repLast,
  output logic             mismatch,
  output logic             fail,
  output logic [IW-1:0]    failIdx
);

  logic [AW-1:0] baseQ;
  logic [IW-1:0] idxQ;
  logic [RW-1:0] repQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ   <= '0;
      idxQ    <= '0;
      repQ    <= '0;
      fail    <= 1'b0;
      failIdx <= '0;
    end else if (strb.load) begin
      baseQ   <= baseAddr;
      idxQ    <= '0;
      repQ    <= '0;
      fail    <= 1'b0;
      failIdx <= '0;
    end else begin
      if (strb.idxClr)      idxQ <= '0;
      else if (strb.idxInc) idxQ <= idxQ + 1'b1;
      if (strb.repClr)      repQ <= '0;
      else if (strb.repInc) repQ <= repQ + 1'b1;
      if (strb.setFail) begin
        fail    <= 1'b1;
        failIdx <= idxQ;
      end
    end
  end

  assign memAddr  = baseQ + AW'(idxQ);
  assign memWdata = patternWord(6'(idxQ));
  assign idxLast  = (idxQ == IW'(WORDS - 1));
  assign repLast  = (repQ == RW'(REPEATS - 1));
  assign mismatch = (memRdata != memWdata);

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> ($stable(memAddr) && $stable(memWdata))); // R7
  AST_FAIL_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> (failIdx <= IW'(WORDS - 1))); // R5

endmodule

// File: rtl/mem_pattern_verify.sv
module mem_pattern_verify
  import mpv_pkg::*;
#(
  parameter int AW      = 16,
  parameter int WORDS   = 64,
  parameter int REPEATS = 10,
  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [AW-1:0]    baseAddr,
  output logic             memReq,
  output logic             memWe,
  output logic [AW-1:0]    memAddr,
  output logic [PAT_W-1:0] memWdata,
  input  logic             memReady,
  input  logic [PAT_W-1:0] memRdata,
  input  logic             memRvalid,
  output logic             done,
  output logic             fail,
  output logic [IW-1:0]    failIdx
);

  mpvStrobe_t strb;
  logic idxLast, repLast, mismatch;

  mpv_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .memReady (memReady),
    .memRvalid(memRvalid),
    .idxLast  (idxLast),
    .repLast  (repLast),
    .mismatch (mismatch),
    .strb     (strb),
    .memReq   (memReq),
    .memWe    (memWe),
    .done     (done)
  );

  mpv_datapath #(.AW(AW), .WORDS(WORDS), .REPEATS(REPEATS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .baseAddr(baseAddr),
    .memRdata(memRdata),
    .memReq  (memReq),
    .memReady(memReady),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .idxLast (idxLast),
    .repLast (repLast),
    .mismatch(mismatch),
    .fail    (fail),
    .failIdx (failIdx)
  );

endmodule

// File: tb/tb_mem_pattern_verify.sv
module tb_mem_pattern_verify;

  localparam int AW = 16;
  localparam int WORDS = 64;
  localparam int REP = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] baseAddr = '0;
  logic memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [31:0] memWdata;
  logic memReady = 1'b0;
  logic [31:0] memRdata = '0;
  logic memRvalid = 1'b0;
  logic done, fail;
  logic [5:0] failIdx;

  always #2 clk = ~clk;

  mem_pattern_verify #(.AW(AW), .WORDS(WORDS), .REPEATS(REP)) dut (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memReady(memReady), .memRdata(memRdata), .memRvalid(memRvalid),
    .done(done), .fail(fail), .failIdx(failIdx)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expPat(input int i);
    logic [31:0] a, b;
    case ((i / 16) % 4)
      0: begin a = 32'h0000_0000; b = 32'hFFFF_FFFF; end
      1: begin a = 32'hAAAA_AAAA; b = 32'h5555_5555; end
      2: begin a = 32'hA5A5_A5A5; b = 32'h5A5A_5A5A; end
      default: begin a = 32'hAA55_AA55; b = 32'h55AA_55AA; end
    endcase
    return ((16'h33CC >> (i % 16)) & 16'h1) != 0 ? b : a;
  endfunction

  // behavioural memory with fault injection
  logic [31:0] memArr [0:255];
  logic [AW-1:0] curBase = '0;
  int wIdx = 0, readCnt = 0;
  int faultWord = 1000, faultRep = 0;
  logic [31:0] faultMask = 32'h1;
  bit afterDone = 0;
  bit snapReq = 0, snapWe = 0, snapReady = 0;
  logic [AW-1:0] snapAddr = '0;
  logic [31:0] snapData = '0;
  bit pending = 0;
  int lat = 0;
  logic [31:0] pendData = '0;

  always @(negedge clk) begin
    if (!rstN) begin
      memReady = 0; memRvalid = 0; pending = 0; snapReq = 0;
    end else begin
      if (memRvalid) memRvalid = 0;
      if (snapReq && snapReady) begin
        chk(!afterDone, "R8 transfer after done", {31'd0, snapWe}, 32'd0);
        if (snapWe) begin
          chk(snapAddr == curBase + AW'(wIdx), "R3 write address", 32'(snapAddr), 32'(curBase + AW'(wIdx)));
          chk(snapData == expPat(wIdx), "R1 R2 write data", snapData, expPat(wIdx));
          chk(readCnt == 0, "R3 write after read", readCnt, 0);
          memArr[snapAddr[7:0]] = snapData;
          wIdx++;
        end else begin
          chk(wIdx == WORDS, "R3 read before all writes", wIdx, WORDS);
          chk(snapAddr == curBase + AW'(readCnt / REP), "R4 read address", 32'(snapAddr), 32'(curBase + AW'(readCnt / REP)));
          pendData = memArr[snapAddr[7:0]];
          if ((readCnt / REP) == faultWord && (readCnt % REP) == faultRep) pendData ^= faultMask;
          readCnt++;
          pending = 1;
          lat = $urandom % 4;
        end
      end
      if (pending) begin
        if (lat == 0) begin
          memRvalid = 1; memRdata = pendData; pending = 0;
        end else lat--;
      end
      memReady = ($urandom % 3) != 0;
      snapReq = memReq; snapWe = memWe; snapAddr = memAddr; snapData = memWdata;
      snapReady = memReady;
    end
  end

  task automatic runOne(input logic [AW-1:0] base, input int fw, input int fr,
                        input bit busyStart, input bit doneStart, input string tag);
    int cnt;
    bit expFail;
    int expReads;
    logic [5:0] expIdx;
    curBase = base; wIdx = 0; readCnt = 0; afterDone = 0;
    faultWord = fw; faultRep = fr; faultMask = $urandom | 32'h1;
    expFail = (fw < WORDS);
    expIdx = expFail ? 6'(fw) : 6'd0;
    expReads = expFail ? fw * REP + fr + 1 : WORDS * REP;
    @(negedge clk); start = 1; baseAddr = base;
    @(negedge clk); start = 0;
    if (busyStart) begin
      repeat (40 + ($urandom % 400)) @(negedge clk);
      if (!done) begin
        start = 1; baseAddr = base ^ 16'h1234;
        @(negedge clk); start = 0;
      end
    end
    cnt = 0;
    while (!done && cnt < 20000) begin @(negedge clk); cnt++; end
    chk(done, {tag, " R9 done timeout"}, 0, 1);
    if (doneStart) start = 1;
    afterDone = 1;
    chk(fail == expFail, {tag, " R5 R6 fail flag"}, fail, expFail);
    chk(failIdx == expIdx, {tag, " R5 R6 failIdx"}, failIdx, expIdx);
    chk(readCnt == expReads, {tag, " R4 R5 read count"}, readCnt, expReads);
    chk(wIdx == WORDS, {tag, " R3 write count"}, wIdx, WORDS);
    @(negedge clk); start = 0;
    chk(!done, {tag, " R9 done one cycle"}, done, 0);
    repeat (6) begin
      @(negedge clk);
      chk(!memReq, {tag, " R8 idle after done"}, memReq, 0);
    end
    chk(fail == expFail && failIdx == expIdx, {tag, " R9 result held"}, {fail, failIdx}, {expFail, expIdx});
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!memReq && !done && !fail && failIdx == 0, "R10 reset state", {memReq, done, fail, failIdx}, 0);
    rstN = 1;
    @(negedge clk);
    chk(!memReq && !done, "R10 idle after reset", {memReq, done}, 0);
    runOne(16'h0100, 1000, 0, 0, 0, "pass");
    runOne(16'h2040, 0, 0, 0, 0, "first read fault");
    runOne(16'h00C0, WORDS - 1, REP - 1, 0, 1, "last read fault + start at done");
    runOne(16'h7F00, 17, 5, 1, 0, "fault + busy start");
    runOne(16'h3333, 1000, 0, 1, 1, "pass + busy start");
    runOne(16'h0010, 40, 0, 0, 0, "group2 fault");
    for (int t = 0; t < 4; t++) begin
      runOne(16'($urandom % 16'hFF00), $urandom % (WORDS + 24), $urandom % REP,
             $urandom % 2, $urandom % 2, "random");
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule